// File: doc/BRIEF.md
# Configurable-Length Serial Word Transmitter

This block is the transmit shifter of a synchronous serial port. Software writes a 3-bit word-length code and an auxiliary-pin mode bit into a small configuration register. Words are handed over through a valid/ready stream port carrying a 24-bit data word. Each word goes out on a single serial line, one bit per bit-clock enable, most significant bit first. A word can be 8, 12, 16, 24 or 32 bit times long. The two 32-bit modes still carry only 24 data bits and fill the remaining 8 bit times by repeating one of the data bits: the last one (trailing pad) or the first one (leading pad).

Back-pressure rules for the data port: `in_ready` is high only while the shifter is idle. A word is taken on a clock edge where both `in_valid` and `in_ready` are high, and `in_ready` then stays low until the bit-clock enable that sends the word's final bit has passed. While `in_ready` is low, `in_valid` and `in_data` are ignored. The length code is captured when the word is taken, so changing the configuration during a word does not affect that word. Short words use the upper bits of the 24-bit input, and the lower bits are dropped.

The auxiliary pin is driven only when synchronous mode is on, the third transmitter is off and the pin is set as an output. Under those conditions the mode bit picks one of two functions. In the first, the pin acts as a drive enable for an external line buffer and is high for exactly the bit times of a word in flight. In the second, the pin carries a general-purpose flag bit.

Top module: `ser_word_tx`

## Requirements
- R1: Length codes 3'b000, 3'b001, 3'b010 and 3'b011 send 8, 12, 16 and 24 bits of `in_data`, starting at bit 23 and moving downward, one bit per `bit_en` cycle.
- R2: Code 3'b100 sends 32 bits: `in_data[23]` down to `in_data[0]`, then `in_data[0]` eight more times.
- R3: Code 3'b101 sends 32 bits: `in_data[23]` eight times, then `in_data[23]` down to `in_data[0]`.
- R4: The reserved codes 3'b110 and 3'b111 send 24 bits, exactly as code 3'b011 does.
- R5: `in_ready` is high when idle. A word is accepted on an edge where `in_valid` and `in_ready` are both high. `in_ready` is low from the next cycle until the cycle after the `bit_en` that sends the last bit, and any `in_valid` during that time is ignored.
- R6: `word_start` is high only in the `bit_en` cycle that sends a word's first bit.
- R7: `tx_sd` changes only after a `bit_en` cycle, and it is 0 while idle.
- R8: With `cfg_aux_sel` stored as 1, `sync_mode`=1, `tx2_en`=0 and `aux_dir_out`=1, `aux_pin` is 1 exactly while a word is in flight (`in_ready` low).
- R9: `aux_drive` equals `sync_mode & ~tx2_en & aux_dir_out`. When it is 1 and the stored mode bit is 0, `aux_pin` follows `aux_flag`. When it is 0, `aux_pin` is 0.
- R10: Hardware reset (`rst_n` low) and a `soft_rst` cycle both set the length code to 3'b000 and the mode bit to 0. A `soft_rst` cycle also aborts any word in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous hardware reset, active low |
| soft_rst | input | 1 | Synchronous software reset |
| cfg_we | input | 1 | Write strobe for the configuration register |
| cfg_len | input | 3 | Word-length code to store |
| cfg_aux_sel | input | 1 | Auxiliary-pin mode bit to store (1 = buffer enable) |
| in_valid | input | 1 | Data word offered |
| in_ready | output | 1 | Shifter idle, word can be accepted |
| in_data | input | 24 | Data word |
| bit_en | input | 1 | Bit-clock enable, one bit per high cycle |
| tx_sd | output | 1 | Serial data out |
| word_start | output | 1 | Marks the cycle that sends a word's first bit |
| sync_mode | input | 1 | Synchronous mode is on |
| tx2_en | input | 1 | Third transmitter is enabled |
| aux_dir_out | input | 1 | Auxiliary pin configured as output |
| aux_flag | input | 1 | General-purpose flag value for the auxiliary pin |
| aux_pin | output | 1 | Auxiliary pin value |
| aux_drive | output | 1 | Auxiliary pin output enable |

## Verification
The auxiliary pin in buffer-enable mode and the shifter's word boundary meet in one cycle. The `bit_en` that sends the last bit also ends the pin's high period, and the next word can be accepted on the edge right after it. The bench sends words back to back and with gaps between `bit_en` pulses, in every length mode. In each sampled cycle it compares `aux_pin` with the word-in-flight state, so an extra or missing bit time shows up as a mismatch. A second collision is a soft reset in the middle of a word: the bench checks that the port is ready and idle on the next cycle and that the following word uses the reset length.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

  typedef enum logic [2:0] {
    LEN_8        = 3'b000,
    LEN_12       = 3'b001,
    LEN_16       = 3'b010,
    LEN_24       = 3'b011,
    LEN_32_TRAIL = 3'b100,
    LEN_32_LEAD  = 3'b101,
    LEN_RSV_A    = 3'b110,
    LEN_RSV_B    = 3'b111
  } len_code_e;

  typedef enum logic [1:0] {
    PAD_NONE  = 2'd0,
    PAD_TRAIL = 2'd1,
    PAD_LEAD  = 2'd2
  } pad_e;

  typedef struct packed {
    logic [7:0] nbits;
    pad_e       pad;
  } word_fmt_t;

  // Reserved codes fall back to a full 24-bit word so the shifter always ends.
  function automatic word_fmt_t decode_len(input logic [2:0] code);
    word_fmt_t f;
    f.pad = PAD_NONE;
    unique case (len_code_e'(code))
      LEN_8:        f.nbits = 8'd8;
      LEN_12:       f.nbits = 8'd12;
      LEN_16:       f.nbits = 8'd16;
      LEN_32_TRAIL: begin f.nbits = 8'd32; f.pad = PAD_TRAIL; end
      LEN_32_LEAD:  begin f.nbits = 8'd32; f.pad = PAD_LEAD;  end
      default:      f.nbits = 8'd24;
    endcase
    return f;
  endfunction

endpackage

// File: rtl/sertx_cfg.sv
module sertx_cfg #(
  parameter int LEN_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_rst,
  input  logic             cfg_we,
  input  logic [LEN_W-1:0] cfg_len,
  input  logic             cfg_aux_sel,
  output logic [LEN_W-1:0] len_q,
  output logic             sel_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q <= '0;
      sel_q <= 1'b0;
    end else if (soft_rst) begin
      len_q <= '0;
      sel_q <= 1'b0;
    end else if (cfg_we) begin
      len_q <= cfg_len;
      sel_q <= cfg_aux_sel;
    end
  end
endmodule

// File: rtl/sertx_framer.sv
module sertx_framer #(
  parameter int DATA_W = 24,
  parameter int PAD_W  = 8,
  parameter int CNT_W  = 6,
  localparam int FRAME_W = DATA_W + PAD_W
) (
  input  logic [2:0]         code,
  input  logic [DATA_W-1:0]  data,
  output logic [FRAME_W-1:0] frame,
  output logic [CNT_W-1:0]   nbits
);
  sertx_pkg::word_fmt_t fmt;

  always_comb begin
    fmt   = sertx_pkg::decode_len(code);
    nbits = CNT_W'(fmt.nbits);
    unique case (fmt.pad)
      sertx_pkg::PAD_TRAIL: frame = {data, {PAD_W{data[0]}}};
      sertx_pkg::PAD_LEAD:  frame = {{PAD_W{data[DATA_W-1]}}, data};
      default:              frame = {data, {PAD_W{1'b0}}};
    endcase
  end
endmodule

// File: rtl/sertx_shift.sv
module sertx_shift #(
  parameter int FRAME_W = 32,
  parameter int CNT_W   = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               soft_rst,
  input  logic               load,
  input  logic [FRAME_W-1:0] frame,
  input  logic [CNT_W-1:0]   nbits,
  input  logic               bit_en,
  output logic               busy,
  output logic               sd,
  output logic               start
);
  logic [FRAME_W-1:0] sh_q;
  logic [CNT_W-1:0]   rem_q;
  logic               first_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q    <= '0;
      rem_q   <= '0;
      busy    <= 1'b0;
      first_q <= 1'b0;
    end else if (soft_rst) begin
      sh_q    <= '0;
      rem_q   <= '0;
      busy    <= 1'b0;
      first_q <= 1'b0;
    end else if (load) begin
      sh_q    <= frame;
      rem_q   <= nbits;
      busy    <= 1'b1;
      first_q <= 1'b1;
    end else if (busy && bit_en) begin
      sh_q    <= {sh_q[FRAME_W-2:0], 1'b0};
      rem_q   <= rem_q - CNT_W'(1);
      first_q <= 1'b0;
      if (rem_q == CNT_W'(1)) busy <= 1'b0;
    end
  end

  assign sd    = busy & sh_q[FRAME_W-1];
  assign start = busy & bit_en & first_q;
endmodule

// File: rtl/sertx_aux.sv
module sertx_aux (
  input  logic sel,
  input  logic sync_mode,
  input  logic tx2_en,
  input  logic dir_out,
  input  logic flag,
  input  logic busy,
  output logic pin,
  output logic drive
);
  always_comb begin
    drive = sync_mode & ~tx2_en & dir_out;
    pin   = drive & (sel ? busy : flag);
  end
endmodule

// File: rtl/ser_word_tx.sv
module ser_word_tx #(
  parameter int DATA_W = 24,
  parameter int PAD_W  = 8,
  localparam int FRAME_W = DATA_W + PAD_W,
  localparam int CNT_W   = $clog2(FRAME_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_len,
  input  logic              cfg_aux_sel,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic              bit_en,
  output logic              tx_sd,
  output logic              word_start,
  input  logic              sync_mode,
  input  logic              tx2_en,
  input  logic              aux_dir_out,
  input  logic              aux_flag,
  output logic              aux_pin,
  output logic              aux_drive
);
  logic [2:0]         cfg_len_q;
  logic               cfg_sel_q;
  logic [FRAME_W-1:0] frame;
  logic [CNT_W-1:0]   nbits;
  logic               busy;
  logic               accept;

  assign in_ready = ~busy;
  assign accept   = in_valid & in_ready;

  sertx_cfg #(.LEN_W(3)) u_cfg (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
    .cfg_we(cfg_we), .cfg_len(cfg_len), .cfg_aux_sel(cfg_aux_sel),
    .len_q(cfg_len_q), .sel_q(cfg_sel_q)
  );

  sertx_framer #(.DATA_W(DATA_W), .PAD_W(PAD_W), .CNT_W(CNT_W)) u_framer (
    .code(cfg_len_q), .data(in_data), .frame(frame), .nbits(nbits)
  );

  sertx_shift #(.FRAME_W(FRAME_W), .CNT_W(CNT_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
    .load(accept), .frame(frame), .nbits(nbits), .bit_en(bit_en),
    .busy(busy), .sd(tx_sd), .start(word_start)
  );

  sertx_aux u_aux (
    .sel(cfg_sel_q), .sync_mode(sync_mode), .tx2_en(tx2_en),
    .dir_out(aux_dir_out), .flag(aux_flag), .busy(busy),
    .pin(aux_pin), .drive(aux_drive)
  );
endmodule

// File: rtl/sertx_chk.sv
module sertx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       soft_rst,
  input logic       in_valid,
  input logic       in_ready,
  input logic       bit_en,
  input logic       word_start,
  input logic       tx_sd,
  input logic       sync_mode,
  input logic       tx2_en,
  input logic       aux_dir_out,
  input logic       aux_flag,
  input logic       aux_pin,
  input logic       aux_drive,
  input logic [2:0] cfg_len_q,
  input logic       cfg_sel_q
);
  assert_ready_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !soft_rst) |=> !in_ready);

  assert_start_in_word_R6: assert property (@(posedge clk) disable iff (!rst_n)
    word_start |-> (bit_en && !in_ready));

  assert_hold_between_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_ready && !bit_en && !soft_rst) |=> $stable(tx_sd));

  assert_idle_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> !tx_sd);

  assert_buffer_enable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_sel_q && sync_mode && !tx2_en && aux_dir_out) |-> (aux_pin == !in_ready));

  assert_flag_follow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_sel_q && aux_drive) |-> (aux_pin == aux_flag));

  assert_pin_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !aux_drive |-> !aux_pin);

  assert_soft_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (cfg_len_q == 3'b000 && !cfg_sel_q && in_ready));
endmodule

bind ser_word_tx sertx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
  .in_valid(in_valid), .in_ready(in_ready), .bit_en(bit_en),
  .word_start(word_start), .tx_sd(tx_sd),
  .sync_mode(sync_mode), .tx2_en(tx2_en), .aux_dir_out(aux_dir_out),
  .aux_flag(aux_flag), .aux_pin(aux_pin), .aux_drive(aux_drive),
  .cfg_len_q(cfg_len_q), .cfg_sel_q(cfg_sel_q)
);

// File: tb/test_ser_word_tx.sv
module test_ser_word_tx;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic soft_rst = 1'b0, cfg_we = 1'b0, cfg_aux_sel = 1'b0;
  logic [2:0] cfg_len = 3'd0;
  logic in_valid = 1'b0, bit_en = 1'b0;
  logic [23:0] in_data = '0;
  logic sync_mode = 1'b0, tx2_en = 1'b0, aux_dir_out = 1'b0, aux_flag = 1'b0;
  logic in_ready, tx_sd, word_start, aux_pin, aux_drive;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  ser_word_tx i_ser_word_tx (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .cfg_we(cfg_we),
    .cfg_len(cfg_len), .cfg_aux_sel(cfg_aux_sel), .in_valid(in_valid),
    .in_ready(in_ready), .in_data(in_data), .bit_en(bit_en), .tx_sd(tx_sd),
    .word_start(word_start), .sync_mode(sync_mode), .tx2_en(tx2_en),
    .aux_dir_out(aux_dir_out), .aux_flag(aux_flag), .aux_pin(aux_pin),
    .aux_drive(aux_drive)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  function automatic int exp_len(input logic [2:0] c);
    case (c)
      3'd0: return 8;
      3'd1: return 12;
      3'd2: return 16;
      3'd4, 3'd5: return 32;
      default: return 24;
    endcase
  endfunction

  function automatic logic exp_bit(input logic [2:0] c, input logic [23:0] d, input int i);
    if (c == 3'd5) return (i < 8) ? d[23] : d[23 - (i - 8)];
    if (c == 3'd4) return (i < 24) ? d[23 - i] : d[0];
    return d[23 - i];
  endfunction

  function automatic string tag_of(input logic [2:0] c);
    case (c)
      3'd4: return "R2";
      3'd5: return "R3";
      3'd6, 3'd7: return "R4";
      default: return "R1";
    endcase
  endfunction

  task automatic set_cfg(input logic [2:0] c, input logic sel);
    cfg_we = 1'b1; cfg_len = c; cfg_aux_sel = sel;
    step();
    cfg_we = 1'b0;
  endtask

  // Sends one word with the stored code expected to be c; checks bits,
  // start pulse, stability during gaps, back-pressure and buffer enable.
  task automatic send_word(input logic [2:0] c, input logic [23:0] d, input int gap,
                           input bit aux_en_mode);
    int n = 0, cyc = 0, ws_err = 0, st_err = 0, aux_err = 0, bit_err = 0, rdy_err = 0;
    int nexp = exp_len(c);
    string tg = tag_of(c);
    #8;
    check(in_ready === 1'b1, "R5", "ready before offer", in_ready, 1);
    in_data = d; in_valid = 1'b1;
    step();
    in_valid = 1'b1; in_data = ~d; // junk offered while busy, must be ignored
    while (!in_ready && cyc < 200) begin
      bit_en = (gap == 0) ? 1'b1 : ((cyc % (gap + 1)) == 0);
      #8;
      if (in_ready !== 1'b0) rdy_err++;
      if (aux_en_mode && aux_pin !== 1'b1) aux_err++;
      if (bit_en) begin
        if (n < 32 && tx_sd !== exp_bit(c, d, n)) bit_err++;
        if (word_start !== (n == 0)) ws_err++;
        n++;
      end else begin
        if (n < nexp && tx_sd !== exp_bit(c, d, n)) st_err++;
        if (word_start !== 1'b0) ws_err++;
      end
      step();
      cyc++;
    end
    bit_en = 1'b0; in_valid = 1'b0;
    #8;
    check(n == nexp, tg, "bit count", n, nexp);
    check(bit_err == 0, tg, "bit mismatches", bit_err, 0);
    check(ws_err == 0, "R6", "word_start errors", ws_err, 0);
    check(st_err == 0 && tx_sd === 1'b0, "R7", "hold/idle errors", st_err, 0);
    check(rdy_err == 0 && in_ready === 1'b1, "R5", "ready low in word, high after", rdy_err, 0);
    if (aux_en_mode)
      check(aux_err == 0 && aux_pin === 1'b0, "R8", "buffer enable errors", aux_err, 0);
    step();
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    check(1'b0, "WATCHDOG", "run hung", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    repeat (3) step();
    rst_n = 1'b1;
    step();
    #8;
    check(in_ready === 1'b1, "R10", "ready after reset", in_ready, 1);
    check(tx_sd === 1'b0 && word_start === 1'b0, "R10", "outputs idle after reset", tx_sd, 0);
    step();
    send_word(3'd0, 24'hB4C000, 0, 1'b0); // reset length is 8

    // Buffer-enable conditions all hold for the sweep.
    sync_mode = 1'b1; tx2_en = 1'b0; aux_dir_out = 1'b1;
    for (int c = 0; c < 8; c++) begin
      set_cfg(3'(c), 1'b1);
      for (int p = 0; p < 5; p++) begin
        logic [23:0] d;
        case (p)
          0: d = 24'h800000;
          1: d = 24'h000001;
          default: d = 24'(32'h9E3779 * (p + 1) + c * 32'h1357);
        endcase
        send_word(3'(c), d, p % 3, 1'b1);
      end
    end

    // Flag mode and disabled pin.
    set_cfg(3'd3, 1'b0);
    aux_flag = 1'b1; #8;
    check(aux_pin === 1'b1 && aux_drive === 1'b1, "R9", "flag high", aux_pin, 1);
    step();
    aux_flag = 1'b0; #8;
    check(aux_pin === 1'b0, "R9", "flag low", aux_pin, 0);
    step();
    set_cfg(3'd3, 1'b1);
    tx2_en = 1'b1;
    in_data = 24'hFFFFFF; in_valid = 1'b1; step(); in_valid = 1'b0;
    bit_en = 1'b1; #8;
    check(aux_pin === 1'b0 && aux_drive === 1'b0, "R9", "pin off when third tx on", aux_pin, 0);
    step(); bit_en = 1'b0;
    tx2_en = 1'b0; #8;
    check(aux_pin === 1'b1 && aux_drive === 1'b1, "R8", "enable back on mid word", aux_pin, 1);

    // Soft reset mid word.
    step();
    soft_rst = 1'b1; step(); soft_rst = 1'b0; #8;
    check(in_ready === 1'b1 && tx_sd === 1'b0, "R10", "soft reset aborts word", in_ready, 1);
    aux_flag = 1'b1; #1;
    check(aux_pin === 1'b1, "R10", "mode bit cleared to flag", aux_pin, 1);
    aux_flag = 1'b0;
    step();
    send_word(3'd0, 24'h5A0000, 1, 1'b0); // length back to 8

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule